// File: doc/BRIEF.md
# Post-Update Floating-Point Load Unit

This unit executes four floating-point loads that return a value to a floating-point register and write a newly formed address back to the integer base register. An operation either adds a sign-extended 16-bit displacement or adds an index register, and loads either a 4-byte single-precision word or an 8-byte double-precision doubleword. The read goes to the base value as it was before the operation. After the read, the sum becomes the new base value. Single-precision data is widened to double format before writeback. Any special or status register is left untouched.

A decoder hands the unit one operation at a time with a valid/ready handshake. The operation carries the register fields, the displacement and the integer operand values already read from the register file. The unit issues one read on a valid/ready request port and waits for a response pulse. It then writes the floating-point result and the new base value in the same cycle. An operation naming integer register 0 as its base is an invalid form. It is refused with a one-cycle flag and has no side effects.

The controller is a state machine with five states:
- `ST_IDLE` accepts an operation.
- `ST_ISSUE` holds the read request until it is taken.
- `ST_AWAIT` waits for the response and captures its data.
- `ST_COMMIT` drives both writebacks.
- `ST_REJECT` raises the invalid-form flag.

The transitions are:
- IDLE→ISSUE on a valid operation with a non-zero base field.
- IDLE→REJECT on a valid operation with base field 0.
- ISSUE→AWAIT when `mem_req_ready` is high.
- AWAIT→COMMIT when `mem_rsp_valid` is high.
- COMMIT→IDLE and REJECT→IDLE unconditionally.

Top module: `fpl_postinc_unit`

## Requirements
- R1: `in_op` bit 1 selects double (1) or single (0), and bit 0 selects the indexed form (1) or the displacement form (0). In the displacement form, `gpr_wdata` equals `base_val` plus `in_disp` sign-extended to 64 bits.
- R2: In the indexed form, `gpr_wdata` equals `base_val` plus `index_val`.
- R3: `mem_req_addr` equals the `base_val` captured at acceptance, never the sum. `mem_req_dword` is 1 for double loads and 0 for single loads.
- R4: While `mem_req_ready` is low, `mem_req_valid` stays high and the request address and size stay unchanged.
- R5: For double loads, `fpr_wdata` equals `mem_rsp_data` unchanged.
- R6: For single loads, the word is taken from bits 31:0 of `mem_rsp_data`. A normal value keeps its sign, its exponent is rebiased by +896, and its 23-bit fraction fills bits 51:29 with zeros below.
- R7: Single zero maps to a double zero of the same sign. Single infinity and NaN map to exponent 0x7FF with the sign kept and the fraction in bits 51:29.
- R8: A single denormal is normalized. The double exponent is 896 minus the count of leading zeros in the 23-bit fraction, and the fraction holds the bits below the leading one, shifted to the top.
- R9: `fpr_we` and `gpr_we` rise together for exactly one cycle, the cycle after the response is taken. `fpr_waddr` is the target field and `gpr_waddr` is the base field.
- R10: A base field of 0 raises `bad_form` for one cycle, the cycle after acceptance. No read request and no writeback follow.
- R11: `in_ready` is high only in the idle state. Operand inputs are sampled only at acceptance.
- R12: The address sum wraps modulo 2^64 with no indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle and accepting |
| in_op | input | 2 | bit1 double, bit0 indexed |
| in_base_idx | input | 5 | Base integer register field |
| in_fpr_idx | input | 5 | Target floating-point register field |
| in_disp | input | 16 | Displacement, signed |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 64 | Read address |
| mem_req_dword | output | 1 | 1 = 8-byte read, 0 = 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| fpr_we | output | 1 | Floating-point writeback enable |
| fpr_waddr | output | 5 | Floating-point destination |
| fpr_wdata | output | 64 | Loaded value, double format |
| gpr_we | output | 1 | Integer writeback enable |
| gpr_waddr | output | 5 | Integer destination (the base field) |
| gpr_wdata | output | 64 | Updated base address |
| bad_form | output | 1 | Invalid form pulse |

## Verification
The hardest case to reach from the ports is the single-precision denormal path. Random 32-bit words almost never have a zero exponent, so the bench feeds denormals directly, including the smallest one (leading-zero count 22) and the largest one (count 0). It also biases part of the random words toward a zero exponent. Post-update ordering is only visible if the base operand changes after acceptance. The bench therefore scrambles `base_val` and `index_val` right after each handshake and holds the request unaccepted for several cycles, so a design that reads the sum or re-samples the inputs shows up at the request port.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_COMMIT,
        ST_REJECT
    } fpl_state_e;

    typedef struct packed {
        logic dbl;
        logic indexed;
    } fpl_op_t;

    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_W      = 64;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int BIAS_GAP  = 896;

endpackage

// File: rtl/fpl_ea_adder.sv
module fpl_ea_adder #(
    parameter int AW     = 64,
    parameter int DISP_W = 16
) (
    input  logic              use_index,
    input  logic [DISP_W-1:0] disp,
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     index,
    output logic [AW-1:0]     sum
);
    logic [AW-1:0] disp_ext;
    logic [AW-1:0] addend;

    assign disp_ext = {{(AW-DISP_W){disp[DISP_W-1]}}, disp};
    assign addend   = use_index ? index : disp_ext;
    assign sum      = base + addend;
endmodule

// File: rtl/fpl_lzc.sv
module fpl_lzc #(
    parameter int W  = 23,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                count = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/fpl_sp_to_dp.sv
module fpl_sp_to_dp
    import fpl_pkg::*;
(
    input  logic [SP_W-1:0] sp,
    output logic [DP_W-1:0] dp
);
    localparam int LZ_W  = $clog2(SP_FRAC_W + 1);
    localparam int PAD_W = DP_FRAC_W - SP_FRAC_W;

    logic                 sgn;
    logic [SP_EXP_W-1:0]  exp_s;
    logic [SP_FRAC_W-1:0] frac_s;
    logic [LZ_W-1:0]      lz;
    logic [SP_FRAC_W-1:0] frac_norm;
    logic [DP_EXP_W-1:0]  exp_norm;
    logic [DP_EXP_W-1:0]  exp_denorm;

    assign sgn    = sp[SP_W-1];
    assign exp_s  = sp[SP_W-2 -: SP_EXP_W];
    assign frac_s = sp[SP_FRAC_W-1:0];

    fpl_lzc #(.W(SP_FRAC_W), .CW(LZ_W)) u_lzc (
        .vec   (frac_s),
        .count (lz)
    );

    assign frac_norm  = frac_s << (lz + LZ_W'(1));
    assign exp_norm   = {{(DP_EXP_W-SP_EXP_W){1'b0}}, exp_s} + DP_EXP_W'(BIAS_GAP);
    assign exp_denorm = DP_EXP_W'(BIAS_GAP) - {{(DP_EXP_W-LZ_W){1'b0}}, lz};

    always_comb begin
        if (exp_s == {SP_EXP_W{1'b1}}) begin
            dp = {sgn, {DP_EXP_W{1'b1}}, frac_s, {PAD_W{1'b0}}};
        end else if (exp_s == '0 && frac_s == '0) begin
            dp = {sgn, {(DP_W-1){1'b0}}};
        end else if (exp_s == '0) begin
            dp = {sgn, exp_denorm, frac_norm, {PAD_W{1'b0}}};
        end else begin
            dp = {sgn, exp_norm, frac_s, {PAD_W{1'b0}}};
        end
    end
endmodule

// File: rtl/fpl_postinc_unit.sv
module fpl_postinc_unit
    import fpl_pkg::*;
#(
    parameter int AW     = 64,
    parameter int DISP_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [IDX_W-1:0]  in_base_idx,
    input  logic [IDX_W-1:0]  in_fpr_idx,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [AW-1:0]     base_val,
    input  logic [AW-1:0]     index_val,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [AW-1:0]     mem_req_addr,
    output logic              mem_req_dword,
    input  logic              mem_rsp_valid,
    input  logic [DP_W-1:0]   mem_rsp_data,
    output logic              fpr_we,
    output logic [IDX_W-1:0]  fpr_waddr,
    output logic [DP_W-1:0]   fpr_wdata,
    output logic              gpr_we,
    output logic [IDX_W-1:0]  gpr_waddr,
    output logic [AW-1:0]     gpr_wdata,
    output logic              bad_form
);
    fpl_state_e state_q, state_d;
    fpl_op_t    op_in, op_q;
    logic [IDX_W-1:0] ra_q, frt_q;
    logic [AW-1:0]    base_q, sum_q, sum_d;
    logic [DP_W-1:0]  data_q, widened;
    logic             accept, ra_zero;

    assign op_in   = fpl_op_t'(in_op);
    assign accept  = in_valid && (state_q == ST_IDLE);
    assign ra_zero = (in_base_idx == '0);

    fpl_ea_adder #(.AW(AW), .DISP_W(DISP_W)) u_adder (
        .use_index (op_in.indexed),
        .disp      (in_disp),
        .base      (base_val),
        .index     (index_val),
        .sum       (sum_d)
    );

    fpl_sp_to_dp u_widen (
        .sp (data_q[SP_W-1:0]),
        .dp (widened)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid) state_d = ra_zero ? ST_REJECT : ST_ISSUE;
            ST_ISSUE:  if (mem_req_ready) state_d = ST_AWAIT;
            ST_AWAIT:  if (mem_rsp_valid) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // operand and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            ra_q   <= '0;
            frt_q  <= '0;
            base_q <= '0;
            sum_q  <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                op_q   <= op_in;
                ra_q   <= in_base_idx;
                frt_q  <= in_fpr_idx;
                base_q <= base_val;
                sum_q  <= sum_d;
            end
            if (state_q == ST_AWAIT && mem_rsp_valid) begin
                data_q <= mem_rsp_data;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready      = 1'b0;
        mem_req_valid = 1'b0;
        fpr_we        = 1'b0;
        gpr_we        = 1'b0;
        bad_form      = 1'b0;
        unique case (state_q)
            ST_IDLE:   in_ready      = 1'b1;
            ST_ISSUE:  mem_req_valid = 1'b1;
            ST_AWAIT:  ;
            ST_COMMIT: begin
                fpr_we = 1'b1;
                gpr_we = 1'b1;
            end
            ST_REJECT: bad_form = 1'b1;
            default:   ;
        endcase
    end

    assign mem_req_addr  = base_q;
    assign mem_req_dword = op_q.dbl;
    assign fpr_waddr     = frt_q;
    assign fpr_wdata     = op_q.dbl ? data_q : widened;
    assign gpr_waddr     = ra_q;
    assign gpr_wdata     = sum_q;
endmodule

// File: rtl/fpl_postinc_unit_chk.sv
module fpl_postinc_unit_chk #(
    parameter int AW    = 64,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [IDX_W-1:0] in_base_idx,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [AW-1:0]    mem_req_addr,
    input logic             mem_req_dword,
    input logic             mem_rsp_valid,
    input logic             fpr_we,
    input logic             gpr_we,
    input logic [IDX_W-1:0] gpr_waddr,
    input logic             bad_form
);
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_dword));

    p_wb_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fpr_we == gpr_we);

    p_wb_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fpr_we |=> !fpr_we);

    p_wb_after_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fpr_we) |-> $past(mem_rsp_valid));

    p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_base_idx == '0 |=> bad_form && !mem_req_valid && !fpr_we);

    p_gpr_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> gpr_waddr != '0);

    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || fpr_we || bad_form) |-> !in_ready);
endmodule

bind fpl_postinc_unit fpl_postinc_unit_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_base_idx   (in_base_idx),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_dword (mem_req_dword),
    .mem_rsp_valid (mem_rsp_valid),
    .fpr_we        (fpr_we),
    .gpr_we        (gpr_we),
    .gpr_waddr     (gpr_waddr),
    .bad_form      (bad_form)
);

// File: tb/tb_fpl_postinc_unit.sv
module tb_fpl_postinc_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = '0;
    logic [4:0]  in_base_idx = '0;
    logic [4:0]  in_fpr_idx = '0;
    logic [15:0] in_disp = '0;
    logic [63:0] base_val = '0;
    logic [63:0] index_val = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_req_dword;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        fpr_we;
    logic [4:0]  fpr_waddr;
    logic [63:0] fpr_wdata;
    logic        gpr_we;
    logic [4:0]  gpr_waddr;
    logic [63:0] gpr_wdata;
    logic        bad_form;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpl_postinc_unit dut (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_widen(input logic [31:0] w);
        logic        s = w[31];
        logic [7:0]  e = w[30:23];
        logic [22:0] f = w[22:0];
        logic [23:0] m;
        int          ex;
        if (e == 8'hFF) return {s, 11'h7FF, f, 29'b0};
        if (e == 0 && f == 0) return {s, 63'b0};
        if (e != 0) return {s, 11'(int'(e) + 896), f, 29'b0};
        m = {1'b0, f};
        ex = 897;
        while (!m[23]) begin
            m = m << 1;
            ex--;
        end
        return {s, 11'(ex), m[22:0], 29'b0};
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [4:0] ra, input logic [4:0] frt,
                          input logic [15:0] disp, input logic [63:0] base, input logic [63:0] idx,
                          input logic [63:0] mdata, input int rdy_wait, input int rsp_wait);
        logic [63:0] exp_sum, exp_fp;
        string t1, tf;
        exp_sum = base + (op[0] ? idx : {{48{disp[15]}}, disp});
        exp_fp  = op[1] ? mdata : ref_widen(mdata[31:0]);
        t1 = op[0] ? "R2" : "R1";
        tf = op[1] ? "R5" : "R6/R7/R8";
        @(negedge clk);
        check(in_ready === 1'b1, "R11 idle ready", 64'(in_ready), 64'd1);
        in_valid = 1'b1; in_op = op; in_base_idx = ra; in_fpr_idx = frt;
        in_disp = disp; base_val = base; index_val = idx;
        @(negedge clk);
        in_valid = 1'b0; base_val = ~base; index_val = {$urandom, $urandom}; in_disp = ~disp;
        if (ra == 0) begin
            check(bad_form === 1'b1, "R10 flag", 64'(bad_form), 64'd1);
            for (int k = 0; k < 3; k++) begin
                check(!mem_req_valid && !fpr_we && !gpr_we, "R10 no side effect",
                      {mem_req_valid, fpr_we, gpr_we}, 64'd0);
                @(negedge clk);
            end
            check(bad_form === 1'b0, "R10 pulse", 64'(bad_form), 64'd0);
            return;
        end
        check(mem_req_valid === 1'b1, "R3 req valid", 64'(mem_req_valid), 64'd1);
        check(mem_req_addr === base, "R3 address", mem_req_addr, base);
        check(mem_req_dword === op[1], "R3 size", 64'(mem_req_dword), 64'(op[1]));
        for (int k = 0; k < rdy_wait; k++) begin
            @(negedge clk);
            check(mem_req_valid && mem_req_addr === base && !in_ready, "R4 hold",
                  mem_req_addr, base);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(mem_req_valid === 1'b0, "R4 drop", 64'(mem_req_valid), 64'd0);
        for (int k = 0; k < rsp_wait; k++) begin
            @(negedge clk);
            check(!fpr_we && !gpr_we, "R9 no early write", {fpr_we, gpr_we}, 64'd0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = mdata;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = {$urandom, $urandom};
        check(fpr_we && gpr_we, "R9 both write", {fpr_we, gpr_we}, 64'd3);
        check(fpr_waddr === frt && gpr_waddr === ra, "R9 addresses", {fpr_waddr, gpr_waddr}, {frt, ra});
        check(gpr_wdata === exp_sum, t1, gpr_wdata, exp_sum);
        check(fpr_wdata === exp_fp, tf, fpr_wdata, exp_fp);
        @(negedge clk);
        check(!fpr_we && !gpr_we && in_ready, "R9 one cycle", {fpr_we, gpr_we, in_ready}, 64'd1);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(in_ready && !mem_req_valid && !fpr_we && !gpr_we && !bad_form, "reset state",
              {in_ready, mem_req_valid, fpr_we, gpr_we, bad_form}, 64'h10);
        rst_n = 1'b1;
        // R1 negative displacement, R6 normal 1.0
        run_op(2'b00, 5'd3, 5'd7, 16'hFFF8, 64'h1000, 64'h0, 64'hDEAD_BEEF_3F80_0000, 2, 1);
        // R2 indexed double, R5
        run_op(2'b11, 5'd4, 5'd9, 16'h0, 64'h2000, 64'h40, 64'h4009_21FB_5444_2D18, 0, 0);
        // R12 wraparound
        run_op(2'b10, 5'd31, 5'd1, 16'h0020, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 64'h1, 1, 3);
        run_op(2'b01, 5'd5, 5'd2, 16'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h0, 0, 0);
        // R7 zeros, infinity, NaN
        run_op(2'b00, 5'd6, 5'd0, 16'h4, 64'h3000, 64'h0, 64'h0000_0000_8000_0000, 0, 0);
        run_op(2'b00, 5'd6, 5'd0, 16'h4, 64'h3000, 64'h0, 64'h0000_0000_0000_0000, 0, 0);
        run_op(2'b01, 5'd6, 5'd11, 16'h0, 64'h3000, 64'h8, 64'h0000_0000_FF80_0000, 0, 1);
        run_op(2'b01, 5'd6, 5'd12, 16'h0, 64'h3000, 64'h8, 64'h0000_0000_7FC0_0001, 0, 1);
        // R8 denormals: smallest, largest, negative
        run_op(2'b00, 5'd8, 5'd13, 16'h8000, 64'h8000, 64'h0, 64'h0000_0000_0000_0001, 1, 0);
        run_op(2'b00, 5'd8, 5'd14, 16'h7FFF, 64'h8000, 64'h0, 64'h0000_0000_007F_FFFF, 0, 0);
        run_op(2'b00, 5'd8, 5'd15, 16'h0, 64'h8000, 64'h0, 64'h0000_0000_8040_0000, 0, 2);
        // R10 base field zero
        run_op(2'b11, 5'd0, 5'd3, 16'h0, 64'h5000, 64'h8, 64'h0, 0, 0);
        run_op(2'b00, 5'd0, 5'd3, 16'h10, 64'h5000, 64'h0, 64'h0, 0, 0);
        // random mix
        for (int n = 0; n < 60; n++) begin
            w = $urandom;
            if (n % 3 == 0) w[30:23] = 8'h00;
            run_op(2'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                   {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, w},
                   int'($urandom % 4), int'($urandom % 4));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule